// File: doc/BRIEF.md
# Reload Down-Counter Timer with Selectable Count Source

This block is a 16-bit down-counter that counts toward zero from a programmed start value. Each count step comes from one of three sources. The first is the system clock divided by a selectable prescaler. The second is a rising edge on an external event pin, with the prescaler bypassed. The third is a falling edge on a slow real-time-clock line. When the counter reaches zero, the block raises an interrupt flag. It can also toggle an output pin. In single-pass mode the counter then halts. In continuous mode it reloads and runs again.

Software controls the timer through a small byte-wide register port with a one-cycle write strobe and a combinational read. A read of the control register returns the interrupt flag and clears it, so servicing the interrupt needs no separate acknowledge write. Both external inputs are sampled into the system clock domain. Each source therefore has a fixed, known latency from pin edge to counter update.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control register, the source register, the reload value and the count all read 0. The `irq` and `tmr_out` ports are Low.
- R2: The register map is: address 0 control, 1 reload low byte, 2 reload high byte, 3 source select, 4 count low byte, 5 count high byte. Control holds run in bit 0, continuous in bit 1, prescale select in bits 3:2 and output enable in bit 4; bit 7 reads the interrupt flag. With the system-clock source, prescale select 0/1/2/3 divides by 4/16/64/256. The first decrement lands D cycles after the write that sets run, where D is the divider. A start value R therefore reaches zero D*R cycles after that write.
- R3: When the count steps from 1 to 0, the interrupt flag is set and `irq` goes High on the same clock edge.
- R4: A read of address 0 returns the flag as it was before the read, and clears it on that clock edge. If the flag is set and the control register is read in the same cycle, the flag stays set.
- R5: In single-pass mode (control bit 1 = 0), the counter stays at 0 once it arrives there, and the run bit reads back 0.
- R6: In continuous mode (control bit 1 = 1), the count becomes the reload value on the clock edge after it reaches 0. Counting then goes on without software action.
- R7: Source select bits 1:0 choose the count source: 0 is the prescaled system clock, 1 is the event pin, 2 is the real-time-clock line, and 3 behaves like 0.
- R8: With the event source, each rising edge of `evt_in` removes exactly one count, whatever the prescale setting. The count changes on the fifth rising clock edge after the pin rises. Pulses of one cycle High and one cycle Low are all counted.
- R9: With the real-time-clock source, the count changes on the second rising clock edge after `rtc_in` falls. Rising edges of `rtc_in` do not change the count.
- R10: `tmr_out` is Low while output enable (control bit 4) is 0. While output enable is 1, `tmr_out` starts Low and toggles on every edge at which the count reaches 0. In continuous mode its period is therefore twice the timeout.
- R11: Writing the reload value while the timer runs leaves the current count untouched. The new value is copied into the count when run next goes from 0 to 1. While run is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active Low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; reading address 0 clears the flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| evt_in | input | 1 | External event pin, asynchronous |
| rtc_in | input | 1 | Slow real-time-clock line, asynchronous |
| irq | output | 1 | Interrupt request, High while the flag is set |
| tmr_out | output | 1 | Toggling timer output |

## Verification
Most internal faults show at the ports within one timeout period or one pin edge. A wrong prescaler mask or reset moves the first `irq` edge by whole prescale periods. A synchroniser of the wrong depth shifts the count change by a cycle, and the count readback taken right before and right after the expected edge catches that shift. A flag that loses its same-cycle race, or a reload that is missed or arrives late, shows at the next control read or count read. The same holds for a `tmr_out` flip-flop that ignores the enable, where the error appears no later than the second end of count.

// File: rtl/rtimer_pkg.sv
// Shared types and helpers for the reload timer.
// Assumes a byte-wide register port and a counter two bytes wide.
package rtimer_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_SRC    = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;

    typedef enum logic [1:0] {
        SRC_SYS = 2'b00,
        SRC_EVT = 2'b01,
        SRC_RTC = 2'b10,
        SRC_ALT = 2'b11
    } src_e;

    // Control fields in bit order 4..0.
    typedef struct packed {
        logic       oen;
        logic [1:0] psel;
        logic       cont;
        logic       run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // log2 of the prescale divider chosen by psel: 4, 16, 64, 256.
    function automatic int presc_shift(input logic [1:0] sel);
        return 2 + 2 * int'(sel);
    endfunction

endpackage

// File: rtl/rtimer_edge.sv
// Samples an asynchronous pin into the clock domain and flags one edge.
// STAGES sampling flops come before the history flop. The pulse is
// combinational from the last two flops, so a counter that uses it
// updates on clock edge STAGES+1 after the pin changes.
// Assumes the pin stays stable for at least one clock period.
module rtimer_edge #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    logic [STAGES:0] sh;

    // Shift the pin through the sampling chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    generate
        if (FALLING) begin : g_fall
            assign pulse = ~sh[STAGES-1] & sh[STAGES];
        end else begin : g_rise
            assign pulse = sh[STAGES-1] & ~sh[STAGES];
        end
    endgenerate
endmodule

// File: rtl/rtimer_tick.sv
// Produces the one-cycle count enable from the selected source: the
// prescaled system clock, the event pin (rising edges, no prescale) or
// the RTC line (falling edges). The prescaler clears while the timer
// is stopped and on the start write.
module rtimer_tick
    import rtimer_pkg::*;
#(
    parameter int PRE_W      = 8,
    parameter int EVT_STAGES = 4,
    parameter int RTC_STAGES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       start,
    input  src_e       src,
    input  logic [1:0] psel,
    input  logic       evt_pin,
    input  logic       rtc_pin,
    output logic       tick
);
    logic [PRE_W-1:0] presc;
    logic [PRE_W-1:0] mask;
    logic             sys_tick;
    logic             evt_pulse;
    logic             rtc_pulse;

    // Free-running prescaler, held at zero unless counting.
    always_ff @(posedge clk) begin
        if (!rst_n || start || !run) presc <= '0;
        else                         presc <= presc + 1'b1;
    end

    // Divider mask; tick once every 2^shift cycles.
    always_comb begin
        mask     = PRE_W'((1 << presc_shift(psel)) - 1);
        sys_tick = ((presc & mask) == mask);
    end

    rtimer_edge #(.STAGES(EVT_STAGES), .FALLING(1'b0)) u_evt (
        .clk(clk), .rst_n(rst_n), .pin(evt_pin), .pulse(evt_pulse)
    );

    rtimer_edge #(.STAGES(RTC_STAGES), .FALLING(1'b1)) u_rtc (
        .clk(clk), .rst_n(rst_n), .pin(rtc_pin), .pulse(rtc_pulse)
    );

    // Source multiplexer; code 3 falls back to the system clock.
    always_comb begin
        unique case (src)
            SRC_EVT: tick = run & evt_pulse;
            SRC_RTC: tick = run & rtc_pulse;
            default: tick = run & sys_tick;
        endcase
    end
endmodule

// File: rtl/rtimer_regs.sv
// Register file: control, reload value, source select, interrupt flag.
// Reads are combinational. A control read clears the flag, but a flag
// set in the same cycle wins. Single-pass completion clears run.
module rtimer_regs
    import rtimer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              eoc,
    input  logic              done,
    input  logic [CNT_W-1:0]  cnt,
    output ctrl_t             ctrl,
    output src_e              src,
    output logic [CNT_W-1:0]  reload,
    output logic              start,
    output logic              flag
);
    localparam int PAD_W = DATA_W - CTRL_W - 1;

    logic wr_ctrl;
    logic rd_ctrl;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign rd_ctrl = rd_en && (addr == A_CTRL);
    assign start   = wr_ctrl && wdata[0] && !ctrl.run;

    // Control register; software write beats single-pass completion.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
        else if (done)    ctrl.run <= 1'b0;
    end

    // Reload bytes and source select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
            src    <= SRC_SYS;
        end else if (wr_en) begin
            if (addr == A_RLD_LO) reload[DATA_W-1:0]     <= wdata;
            if (addr == A_RLD_HI) reload[CNT_W-1:DATA_W] <= wdata;
            if (addr == A_SRC)    src <= src_e'(wdata[1:0]);
        end
    end

    // Interrupt flag: set has priority over clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (eoc)     flag <= 1'b1;
        else if (rd_ctrl) flag <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = {flag, {PAD_W{1'b0}}, ctrl};
            A_RLD_LO: rdata = reload[DATA_W-1:0];
            A_RLD_HI: rdata = reload[CNT_W-1:DATA_W];
            A_SRC:    rdata = DATA_W'(src);
            A_CNT_LO: rdata = cnt[DATA_W-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:DATA_W];
            default:  rdata = '0;
        endcase
    end

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> flag);
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !eoc) |=> !flag);
    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_ctrl) |=> !ctrl.run);
endmodule

// File: rtl/rtimer_core.sv
// Down-counter and output toggle. Loads the reload value on start,
// decrements on each tick, flags end of count on the 1->0 step, and in
// continuous mode reloads on the cycle after reaching zero.
// Assumes ticks are at least two cycles apart, so none falls on the
// reload cycle.
module rtimer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cont,
    input  logic             oen,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             eoc,
    output logic             done,
    output logic             tout
);
    logic at_zero;

    assign at_zero = (cnt == '0);
    assign eoc     = run && tick && (cnt == CNT_W'(1));
    assign done    = eoc && !cont;

    // Counter: load, reload, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (start)             cnt <= reload;
        else if (run) begin
            if (cont && at_zero)    cnt <= reload;
            else if (tick && !at_zero) cnt <= cnt - 1'b1;
        end
    end

    // Output pin: Low when disabled, toggles at each end of count.
    always_ff @(posedge clk) begin
        if (!rst_n || !oen) tout <= 1'b0;
        else if (eoc)       tout <= ~tout;
    end

    a_r3_zero_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> (cnt == '0));
    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cont && at_zero && !start) |=> (cnt == $past(reload)));
    a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (oen && eoc) |=> (tout != $past(tout)));
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !oen |=> !tout);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt));
endmodule

// File: rtl/reload_timer.sv
// Top level of the reload down-counter timer. Connects the register
// file, the tick generator and the counter core. Both external pins
// are asynchronous and get sampled inside the tick generator.
module reload_timer
    import rtimer_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PRE_W      = 8,
    parameter int EVT_STAGES = 4,
    parameter int RTC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              evt_in,
    input  logic              rtc_in,
    output logic              irq,
    output logic              tmr_out
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t            ctrl;
    src_e             src;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             start;
    logic             tick;
    logic             eoc;
    logic             done;

    rtimer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
        .rd_en(bus_rd), .wdata(bus_wdata), .rdata(bus_rdata),
        .eoc(eoc), .done(done), .cnt(cnt), .ctrl(ctrl), .src(src),
        .reload(reload), .start(start), .flag(irq)
    );

    rtimer_tick #(.PRE_W(PRE_W), .EVT_STAGES(EVT_STAGES),
                  .RTC_STAGES(RTC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .start(start),
        .src(src), .psel(ctrl.psel), .evt_pin(evt_in), .rtc_pin(rtc_in),
        .tick(tick)
    );

    rtimer_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .cont(ctrl.cont),
        .oen(ctrl.oen), .start(start), .tick(tick), .reload(reload),
        .cnt(cnt), .eoc(eoc), .done(done), .tout(tmr_out)
    );
endmodule

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_in = 1'b0;
    logic       rtc_in = 1'b1;
    logic       irq;
    logic       tmr_out;

    int ntest = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    reload_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .rtc_in(rtc_in), .irq(irq), .tmr_out(tmr_out)
    );

    // {prescale select, start value, cycles from start write to zero}
    localparam logic [33:0] VEC [0:5] = '{
        {2'd0, 16'd3,   16'd12},
        {2'd1, 16'd2,   16'd32},
        {2'd2, 16'd1,   16'd64},
        {2'd3, 16'd1,   16'd256},
        {2'd0, 16'd100, 16'd400},
        {2'd1, 16'd5,   16'd80}
    };

    task automatic chk(input string req, input int act, input int exp);
        ntest++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Both tasks start at a falling edge and end at the next one.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [1:0] ps;
        logic [15:0] rv;
        int cyc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 tmr_out", int'(tmr_out), 0);
        rd(3'd0, d); chk("R1 ctrl", int'(d), 0);
        rd(3'd3, d); chk("R1 source", int'(d), 0);
        rd(3'd1, d); chk("R1 reload", int'(d), 0);
        rd(3'd4, d); chk("R1 count", int'(d), 0);

        // R2/R3/R5 table: single-pass from the prescaled clock
        for (int i = 0; i < 6; i++) begin
            ps  = VEC[i][33:32];
            rv  = VEC[i][31:16];
            cyc = int'(VEC[i][15:0]);
            wr(3'd3, 8'h00);
            wr(3'd1, rv[7:0]);
            wr(3'd2, rv[15:8]);
            wr(3'd0, {4'b0, ps, 2'b01});
            repeat (cyc - 1) @(negedge clk);
            chk("R2 irq before timeout", int'(irq), 0);
            @(negedge clk);
            chk("R3 irq at timeout", int'(irq), 1);
            rd(3'd4, d); chk("R5 count held at zero", int'(d), 0);
            rd(3'd0, d);
            chk("R5 run bit cleared", int'(d[0]), 0);
            chk("R4 flag read as set", int'(d[7]), 1);
            chk("R4 irq cleared by read", int'(irq), 0);
        end

        // R8 event pin: latency and bypassed prescaler (psel=3)
        wr(3'd3, 8'h01);
        wr(3'd1, 8'd10);
        wr(3'd2, 8'd0);
        wr(3'd0, 8'h0F);
        evt_in = 1'b1;
        repeat (3) @(negedge clk);
        evt_in = 1'b0;
        @(negedge clk);
        rd(3'd4, d); chk("R8 count after 4th edge", int'(d), 10);
        rd(3'd4, d); chk("R8 count after 5th edge", int'(d), 9);
        for (int k = 0; k < 4; k++) begin
            evt_in = 1'b1; @(negedge clk);
            evt_in = 1'b0; @(negedge clk);
        end
        repeat (6) @(negedge clk);
        rd(3'd4, d); chk("R8 half-rate pulses counted", int'(d), 5);
        wr(3'd0, 8'h00);

        // R9 RTC line: falling edge counts, rising edge does not
        wr(3'd3, 8'h02);
        wr(3'd1, 8'd5);
        wr(3'd0, 8'h0F);
        rtc_in = 1'b0;
        @(negedge clk);
        rd(3'd4, d); chk("R9 count after 1st edge", int'(d), 5);
        rd(3'd4, d); chk("R9 count after 2nd edge", int'(d), 4);
        rtc_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(3'd4, d); chk("R9 rising edge ignored", int'(d), 4);
        rd(3'd3, d); chk("R7 source readback", int'(d), 2);
        wr(3'd0, 8'h00);

        // R6/R10 continuous mode with output enabled, divide by 4
        wr(3'd3, 8'h00);
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h13);
        chk("R10 output starts low", int'(tmr_out), 0);
        repeat (7) @(negedge clk);
        chk("R10 output low before timeout", int'(tmr_out), 0);
        @(negedge clk);
        chk("R10 output toggled high", int'(tmr_out), 1);
        chk("R3 irq continuous", int'(irq), 1);
        rd(3'd4, d); chk("R6 count at zero", int'(d), 0);
        rd(3'd4, d); chk("R6 reloaded next cycle", int'(d), 2);
        repeat (6) @(negedge clk);
        chk("R10 output toggled low", int'(tmr_out), 0);
        rd(3'd0, d); chk("R6 still running", int'(d[0]), 1);
        chk("R4 irq cleared", int'(irq), 0);
        wr(3'd0, 8'h03);
        repeat (12) @(negedge clk);
        chk("R10 output stays low when disabled", int'(tmr_out), 0);
        chk("R6 second timeout sets irq", int'(irq), 1);
        wr(3'd0, 8'h00);
        rd(3'd0, d);

        // R4 set and clear in the same cycle: set wins
        wr(3'd0, 8'h01);
        repeat (7) @(negedge clk);
        rd(3'd0, d); chk("R4 old flag value read", int'(d[7]), 0);
        chk("R4 set beats clear", int'(irq), 1);
        rd(3'd0, d); chk("R4 flag visible", int'(d[7]), 1);
        chk("R4 cleared afterwards", int'(irq), 0);

        // R11 reload written while running / while stopped
        wr(3'd1, 8'd50);
        wr(3'd0, 8'h0D);
        wr(3'd1, 8'd7);
        rd(3'd4, d); chk("R11 count unchanged by reload write", int'(d), 50);
        wr(3'd0, 8'h00);
        rd(3'd4, d); chk("R11 count frozen when stopped", int'(d), 50);
        wr(3'd0, 8'h01);
        rd(3'd4, d); chk("R11 new reload loaded on start", int'(d), 7);
        wr(3'd0, 8'h00);

        // R7 code 3 behaves as the system clock
        wr(3'd3, 8'h03);
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h01);
        repeat (7) @(negedge clk);
        chk("R7 code 3 no early timeout", int'(irq), 0);
        @(negedge clk);
        chk("R7 code 3 counts system clock", int'(irq), 1);

        $display("[TB] %0d tests run, %0d failed", ntest, nfail);
        $finish;
    end
endmodule